// File: doc/BRIEF.md
# Parallel Flash Identifier Reader

This block reads the manufacturer and device identifiers from a bank of byte-wide parallel NOR flash devices. The devices run in lockstep on one shared data bus, and each device owns its own byte lane. A one-cycle start pulse launches a fixed run of six bus accesses on a simple master port:

- two unlock writes,
- the identify-mode command,
- one read that returns the manufacturer word,
- one read that returns the device word,
- a final write that returns the devices to array-read mode.

Each access completes in the cycle where the slave raises the acknowledge. The block then reports one manufacturer byte and one device byte per device, and raises a one-cycle done flag.

A chip-type input picks the addressing variant and is sampled with the start pulse. The two variants differ in two ways:
- The unlock address for the second type is the bitwise complement of the first type's unlock address. Parts of that type, used byte-wide, see every address pin moved by one position.
- The second type reads its identifiers one address higher.

Lane order is reversed when the identifiers are reported.

Top module: `flash_id_seq`

## Requirements
- R1: After reset, busy, done, bus_wr and bus_rd are low, and mfr_id and dev_id are all zeros.
- R2: The first access writes 0xAA on every byte lane to the unlock address U. The second access writes 0x55 on every lane to the bitwise complement of U.
- R3: U is 0x55555555 when chip_b was 0 at start, and 0xAAAAAAAA when chip_b was 1 at start (bit i of U is 1 for even i with chip_b = 0, and for odd i with chip_b = 1).
- R4: The third access writes 0x90 on every lane to U.
- R5: The fourth and fifth accesses are reads. They use addresses 0 and 1 when chip_b = 0, and addresses 1 and 2 when chip_b = 1. The fourth read gives the manufacturer word and the fifth read gives the device word.
- R6: The reported byte of device k, mfr_id[8k+7:8k] and dev_id[8k+7:8k], is lane 3−k (bits [8(3−k)+7:8(3−k)]) of the matching read word.
- R7: The sixth and last access writes 0xF0 on every lane to address 0.
- R8: An access keeps its strobe, address and write data unchanged until bus_ack is high. Exactly one access completes per acknowledged cycle.
- R9: done is high for exactly one cycle, the cycle after the exit write is acknowledged. busy is low in that cycle.
- R10: A start pulse while busy is high is ignored. The run in progress issues no extra access and is not restarted.
- R11: mfr_id and dev_id keep their values from the end of a run until the reads of the next run overwrite them.
- R12: A start pulse in the cycle where done is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run an identification |
| chip_b | input | 1 | Addressing variant, sampled with start |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data, one byte lane per device |
| bus_rdata | input | 32 | Read data, valid when bus_ack is high on a read |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_ack | input | 1 | Completes the current access in this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mfr_id | output | 32 | Manufacturer bytes, device k in bits [8k+7:8k] |
| dev_id | output | 32 | Device bytes, device k in bits [8k+7:8k] |

## Verification
Two functions can meet in one cycle: the end-of-run done pulse and the acceptance of a new start. The bench watches for the done pulse and places a start pulse in that same cycle. It then expects a second complete six-access run, with a second done pulse.

The opposite case is a start that lands mid-run while the acknowledges are slowed down. That case is judged by the access log, which must stay at exactly six entries, and by identifiers that stay correct.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UNL1  = 3'd1,
      ST_UNL2  = 3'd2,
      ST_CMD   = 3'd3,
      ST_RDMFR = 3'd4,
      ST_RDDEV = 3'd5,
      ST_EXIT  = 3'd6
   } step_e;

   localparam logic [7:0] BYTE_UNL1 = 8'hAA;
   localparam logic [7:0] BYTE_UNL2 = 8'h55;
   localparam logic [7:0] BYTE_IDENT = 8'h90;
   localparam logic [7:0] BYTE_EXIT = 8'hF0;
endpackage

// File: rtl/fid_ctrl.sv
module fid_ctrl
   import flash_id_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  bus_ack,
   output step_e step,
   output logic  busy,
   output logic  done
);
   step_e step_q, step_d;

   always_comb begin
      step_d = step_q;
      unique case (step_q)
         ST_IDLE:  if (start)   step_d = ST_UNL1;
         ST_UNL1:  if (bus_ack) step_d = ST_UNL2;
         ST_UNL2:  if (bus_ack) step_d = ST_CMD;
         ST_CMD:   if (bus_ack) step_d = ST_RDMFR;
         ST_RDMFR: if (bus_ack) step_d = ST_RDDEV;
         ST_RDDEV: if (bus_ack) step_d = ST_EXIT;
         ST_EXIT:  if (bus_ack) step_d = ST_IDLE;
         default:               step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         done   <= 1'b0;
      end else begin
         step_q <= step_d;
         done   <= (step_q == ST_EXIT) && bus_ack;
      end
   end

   assign step = step_q;
   assign busy = (step_q != ST_IDLE);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_ack) |=> busy && $stable(step));
endmodule

// File: rtl/fid_cmd.sv
module fid_cmd
   import flash_id_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4,
   localparam int DATA_W = 8 * LANES
)(
   input  step_e              step,
   input  logic               chip_b,
   output logic [ADDR_W-1:0]  addr,
   output logic [DATA_W-1:0]  wdata,
   output logic               wr,
   output logic               rd
);
   logic [ADDR_W-1:0] unl_a;

   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_unl
      localparam logic EVEN = ((gi % 2) == 0);
      assign unl_a[gi] = chip_b ? ~EVEN : EVEN;
   end

   logic [ADDR_W-1:0] id_base;
   assign id_base = chip_b ? ADDR_W'(1) : ADDR_W'(0);

   always_comb begin
      addr  = '0;
      wdata = '0;
      wr    = 1'b0;
      rd    = 1'b0;
      unique case (step)
         ST_UNL1:  begin addr = unl_a;  wdata = {LANES{BYTE_UNL1}};  wr = 1'b1; end
         ST_UNL2:  begin addr = ~unl_a; wdata = {LANES{BYTE_UNL2}};  wr = 1'b1; end
         ST_CMD:   begin addr = unl_a;  wdata = {LANES{BYTE_IDENT}}; wr = 1'b1; end
         ST_RDMFR: begin addr = id_base;             rd = 1'b1; end
         ST_RDDEV: begin addr = id_base + ADDR_W'(1); rd = 1'b1; end
         ST_EXIT:  begin addr = '0;     wdata = {LANES{BYTE_EXIT}};  wr = 1'b1; end
         default:  ;
      endcase
   end

   // R8
   strb_excl_chk: assert final (!(wr && rd));
endmodule

// File: rtl/fid_lanes.sv
module fid_lanes
   import flash_id_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DATA_W = 8 * LANES
)(
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mfr_id,
   output logic [DATA_W-1:0] dev_id
);
   logic take_mfr, take_dev;
   assign take_mfr = bus_ack && (step == ST_RDMFR);
   assign take_dev = bus_ack && (step == ST_RDDEV);

   for (genvar k = 0; k < LANES; k++) begin : g_dev
      localparam int LN = LANES - 1 - k;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mfr_id[8*k +: 8] <= '0;
            dev_id[8*k +: 8] <= '0;
         end else begin
            if (take_mfr) mfr_id[8*k +: 8] <= rdata[8*LN +: 8];
            if (take_dev) dev_id[8*k +: 8] <= rdata[8*LN +: 8];
         end
      end
   end

   // R11
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_mfr || take_dev) |=> $stable(mfr_id) && $stable(dev_id));
endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq
   import flash_id_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4,
   localparam int DATA_W = 8 * LANES
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              chip_b,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic              bus_ack,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] mfr_id,
   output logic [DATA_W-1:0] dev_id
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   step_e step;
   logic  type_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              type_q <= 1'b0;
      else if (start && !busy) type_q <= chip_b;
   end

   fid_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .bus_ack(bus_ack),
      .step(step), .busy(busy), .done(done)
   );

   fid_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) i_cmd (
      .step(step), .chip_b(type_q), .addr(bus_addr), .wdata(bus_wdata),
      .wr(bus_wr), .rd(bus_rd)
   );

   fid_lanes #(.LANES(LANES)) i_lanes (
      .clk(clk), .rst_n(rst_n), .step(step), .bus_ack(bus_ack),
      .rdata(bus_rdata), .mfr_id(mfr_id), .dev_id(dev_id)
   );

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !bus_ack) |=>
         (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd)) &&
         $stable(bus_addr) && $stable(bus_wdata));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !bus_wr && !bus_rd);
endmodule

// File: tb/test_flash_id_seq.sv
module test_flash_id_seq;
   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        chip_b = 1'b0;
   logic [31:0] bus_addr, bus_wdata, mfr_id, dev_id;
   logic [31:0] bus_rdata = '0;
   logic        bus_wr, bus_rd, busy, done;
   logic        bus_ack = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   flash_id_seq i_flash_id_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .chip_b(chip_b),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ack(bus_ack),
      .busy(busy), .done(done), .mfr_id(mfr_id), .dev_id(dev_id)
   );

   typedef struct packed {
      logic        chip;
      logic [31:0] mfr;
      logic [31:0] dev;
      logic [1:0]  dly;
   } vec_t;

   localparam vec_t VEC [0:3] = '{
      '{1'b0, 32'hBF_BF_BF_BF, 32'hB7_B7_B7_B7, 2'd0},
      '{1'b1, 32'h20_21_22_23, 32'hD2_D3_D4_D5, 2'd1},
      '{1'b0, 32'h01_02_03_04, 32'hA1_B2_C3_D4, 2'd3},
      '{1'b1, 32'hC2_37_01_EF, 32'h5A_A5_0F_F0, 2'd2}
   };

   int n_cmp = 0, n_bad = 0;
   int lg_n = 0, done_n = 0, done_busy = 0;
   logic        lg_wr   [0:15];
   logic [31:0] lg_addr [0:15];
   logic [31:0] lg_data [0:15];
   logic [1:0]  dly = 2'd0;
   logic [31:0] sl_mfr = '0, sl_dev = '0, sl_base = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   // slave model
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (done) begin
            done_n++;
            if (busy) done_busy++;
         end
         if (bus_wr || bus_rd) begin
            if (cnt >= int'(dly)) begin
               bus_ack = 1'b1;
               cnt = 0;
               if (lg_n < 16) begin
                  lg_wr[lg_n] = bus_wr;
                  lg_addr[lg_n] = bus_addr;
                  lg_data[lg_n] = bus_wdata;
               end
               lg_n++;
               if (bus_rd && bus_addr == sl_base)             bus_rdata = sl_mfr;
               else if (bus_rd && bus_addr == sl_base + 32'd1) bus_rdata = sl_dev;
               else                                           bus_rdata = 32'hDEAD_BEEF;
            end else begin
               bus_ack = 1'b0;
               cnt++;
            end
         end else begin
            bus_ack = 1'b0;
            cnt = 0;
         end
      end
   end

   task automatic setup(input vec_t v);
      chip_b  = v.chip;
      dly     = v.dly;
      sl_mfr  = v.mfr;
      sl_dev  = v.dev;
      sl_base = v.chip ? 32'd1 : 32'd0;
   endtask

   task automatic wait_done(input int target);
      while (done_n < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_run(input vec_t v);
      logic [31:0] u;
      u = v.chip ? 32'hAAAA_AAAA : 32'h5555_5555;
      chk("R8 access count", 32'(lg_n), 32'd6);
      chk("R2 unlock1 kind", {31'd0, lg_wr[0]}, 32'd1);
      chk("R3 unlock1 addr", lg_addr[0], u);
      chk("R2 unlock1 data", lg_data[0], 32'hAAAA_AAAA);
      chk("R2 unlock2 addr", lg_addr[1], ~u);
      chk("R2 unlock2 data", lg_data[1], 32'h5555_5555);
      chk("R4 ident addr", lg_addr[2], u);
      chk("R4 ident data", lg_data[2], 32'h9090_9090);
      chk("R5 mfr read kind", {31'd0, lg_wr[3]}, 32'd0);
      chk("R5 mfr read addr", lg_addr[3], sl_base);
      chk("R5 dev read kind", {31'd0, lg_wr[4]}, 32'd0);
      chk("R5 dev read addr", lg_addr[4], sl_base + 32'd1);
      chk("R7 exit kind", {31'd0, lg_wr[5]}, 32'd1);
      chk("R7 exit addr", lg_addr[5], 32'd0);
      chk("R7 exit data", lg_data[5], 32'hF0F0_F0F0);
      chk("R6 mfr lanes", mfr_id, rev(v.mfr));
      chk("R6 dev lanes", dev_id, rev(v.dev));
   endtask

   // watchdog
   initial begin
      #(CLK_P * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 strobes", {30'd0, bus_wr, bus_rd}, 32'd0);
      chk("R1 mfr_id", mfr_id, 32'd0);
      chk("R1 dev_id", dev_id, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table
      for (int i = 0; i < 4; i++) begin
         int base_done;
         setup(VEC[i]);
         lg_n = 0;
         base_done = done_n;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R9 busy during run", {31'd0, busy}, 32'd1);
         wait_done(base_done + 1);
         check_run(VEC[i]);
         chk("R9 single done", 32'(done_n - base_done), 32'd1);
      end
      chk("R9 busy low with done", 32'(done_busy), 32'd0);

      // R11: identifiers hold while idle even when slave data changes
      sl_mfr = 32'h1111_1111;
      sl_dev = 32'h2222_2222;
      repeat (5) @(negedge clk);
      chk("R11 mfr hold", mfr_id, rev(VEC[3].mfr));
      chk("R11 dev hold", dev_id, rev(VEC[3].dev));

      // R10: start while busy is ignored
      begin
         int base_done;
         setup(VEC[2]);
         lg_n = 0;
         base_done = done_n;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (4) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done(base_done + 1);
         repeat (10) @(negedge clk);
         chk("R10 no restart count", 32'(lg_n), 32'd6);
         chk("R10 one done", 32'(done_n - base_done), 32'd1);
         check_run(VEC[2]);
      end

      // R12: start in the done cycle is accepted
      begin
         int base_done;
         setup(VEC[0]);
         lg_n = 0;
         base_done = done_n;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (!done) @(negedge clk);
         setup(VEC[1]);
         start = 1'b1;
         @(negedge clk);
         lg_n = 0;
         start = 1'b0;
         chk("R12 restart busy", {31'd0, busy}, 32'd1);
         wait_done(base_done + 2);
         check_run(VEC[1]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule